// File: doc/BRIEF.md
# Six-Mode Programmable Interval Counter

This block is a single down-counting timer channel with a configurable period. It advances only on cycles where a count-enable strobe (`tick`) is high. That strobe is derived elsewhere from the timer's input clock. A load strobe captures a reload value and an operating mode together and restarts the channel. From then on the block drives a live count and an output signal whose shape depends on the mode: a level that rises at terminal count, a one-shot window, a periodic low pulse, a square wave, or a single strobe.

The gate input has two roles, chosen by the mode. In the retriggerable modes its rising edge restarts the period from the stored reload value. In the other modes its level only allows or suspends counting. A reload value of zero stands for a period of 65536 ticks. The count is binary. Bus decoding, latching and interrupt delivery live outside this block.

Top module: `prog_interval_counter`

## Requirements
- R1: After reset, `count` is 0 and `out` is low, and both stay so until the first load. At any time, `count` and `out` change only in the cycle after a load, a gate restart or a counted tick.
- R2: When `load` is high, the block captures `mode` and `load_val` at that clock edge, and the next cycle shows `count` equal to `load_val`. Mode codes 6 and 7 act as modes 2 and 3. The elapsed tick count E restarts at 0.
- R3: A `load_val` of 0 gives a period N of 65536. Any other value gives N equal to `load_val`.
- R4: Mode 0. `out` is low while E < N and high once E >= N, and it stays high until the next load. `count` equals (N - E) mod 65536.
- R5: Mode 1. `out` and `count` follow the same rule as mode 0. Counting continues whatever the gate level.
- R6: Mode 2. `count` runs N, N-1, … 1 and then reloads to N. `out` is low only while E is a nonzero multiple of N, and high otherwise.
- R7: Mode 3. `out` is high while (E mod N) < (N+1)/2 (integer division) and low otherwise. `count` equals N - ((2E) mod N), so it falls by two per tick.
- R8: Modes 4 and 5. `out` is high only while E equals N. `count` equals (N - E) mod 65536.
- R9: In modes 1, 2, 3 and 5, a rising edge on `gate` after a load resets E to 0 and keeps the stored mode and N.
- R10: In modes 0, 2, 3 and 4, a tick is counted only while `gate` is high. In modes 1 and 5 every tick is counted.
- R11: A load takes priority over a restart and over a tick in the same cycle. A restart takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable strobe |
| load | input | 1 | Load strobe: captures mode and reload value |
| load_val | input | 16 | Reload value (0 means 65536) |
| mode | input | 3 | Operating mode, sampled with load |
| gate | input | 1 | Gate: restart edge or count enable, by mode |
| count | output | 16 | Live current count |
| out | output | 1 | Mode-dependent timer output |

## Verification
The embedded assertions check on every cycle the rules that involve only one or two cycles:
- the loaded value appears on `count` one cycle after a load;
- the mode-0 output stays high once it has risen;
- a low gate freezes the count in the gated modes;
- the count holds when nothing happens;
- the mode-4/5 strobe drops after one counted tick;
- mode 2 reloads after reaching 1.

The waveform shapes over whole periods need the bench scenarios. These cover the square-wave duty split for odd and even N, repeated pulses, the 65536-tick period from a zero load, retrigger edges and priority collisions. The bench compares each cycle against a model driven by elapsed ticks.

// File: rtl/prog_interval_counter.sv
module prog_interval_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [2:0]   mode,
  input  logic         gate,
  output logic [W-1:0] count,
  output logic         out
);
  localparam int PW = W + 1;
  localparam logic [PW-1:0] FULL = {1'b1, {W{1'b0}}};
  localparam logic [PW-1:0] ONE  = PW'(1);
  localparam logic [PW-1:0] TWO  = PW'(2);

  logic [2:0]    md_q;
  logic [PW-1:0] n_q, c_q, ph_q, c_nx, ph_nx, c_m3;
  logic          valid_q, started_q, gate_q;

  wire [2:0]    md_in    = (mode[2] & mode[1]) ? {1'b0, mode[1:0]} : mode;
  wire [PW-1:0] n_in     = (load_val == '0) ? FULL : {1'b0, load_val};
  wire          periodic = (md_q == 3'd2) || (md_q == 3'd3);
  wire          free_run = (md_q == 3'd1) || (md_q == 3'd5);
  wire          retrig   = free_run || periodic;
  wire          restart  = valid_q & gate & ~gate_q & retrig;
  wire          step     = valid_q & tick & ~load & ~restart & (gate | free_run);
  wire [PW-1:0] ph_inc   = ph_q + ONE;
  wire [PW-1:0] half     = (n_q + ONE) >> 1;

  assign c_m3 = (c_q > TWO) ? c_q - TWO : c_q + n_q - TWO;

  always_comb begin
    case (md_q)
      3'd2:    c_nx = (c_q == ONE) ? n_q : c_q - ONE;
      3'd3:    c_nx = (c_m3 == '0) ? n_q : c_m3;
      default: c_nx = {1'b0, c_q[W-1:0] - W'(1)};
    endcase
    if (periodic) ph_nx = (ph_inc == n_q) ? '0 : ph_inc;
    else          ph_nx = (ph_q <= n_q) ? ph_inc : ph_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      md_q <= '0; n_q <= '0; c_q <= '0; ph_q <= '0;
      valid_q <= 1'b0; started_q <= 1'b0; gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (load) begin
        md_q <= md_in; n_q <= n_in; c_q <= n_in; ph_q <= '0;
        valid_q <= 1'b1; started_q <= 1'b0;
      end else if (restart) begin
        c_q <= n_q; ph_q <= '0; started_q <= 1'b0;
      end else if (step) begin
        c_q <= c_nx; ph_q <= ph_nx; started_q <= 1'b1;
      end
    end
  end

  logic out_m;
  always_comb begin
    case (md_q)
      3'd0, 3'd1: out_m = ph_q >= n_q;
      3'd2:       out_m = ~(started_q && ph_q == '0);
      3'd3:       out_m = ph_q < half;
      3'd4, 3'd5: out_m = ph_q == n_q;
      default:    out_m = 1'b0;
    endcase
  end

  assign count = c_q[W-1:0];
  assign out   = valid_q & out_m;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val)); // R2
  AST_M0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && md_q == 3'd0 && out && !load) |=> out); // R4
  AST_GATE_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !load && !gate && (md_q == 3'd0 || md_q == 3'd4)) |=> $stable(count)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !restart) |=> ($stable(count) && $stable(out))); // R1
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && (md_q == 3'd4 || md_q == 3'd5) && out && step) |=> !out); // R8
  AST_M2_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && md_q == 3'd2 && step && count == W'(1)) |=> count == $past(n_q[W-1:0])); // R6
endmodule

// File: tb/prog_interval_counter_tb.sv
module prog_interval_counter_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, load = 1'b0, gate = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode = '0;
  logic [15:0] count;
  logic        out;

  prog_interval_counter u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .load_val(load_val), .mode(mode), .gate(gate), .count(count), .out(out));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int m_mode = 0;
  longint m_n = 1, m_e = 0;
  bit m_valid = 0, m_gprev = 0;

  function automatic logic [15:0] f_count();
    longint v;
    if (!m_valid) return 16'h0;
    case (m_mode)
      2: v = m_n - (m_e % m_n);
      3: v = m_n - ((2 * m_e) % m_n);
      default: v = ((m_n - m_e) % 65536 + 65536) % 65536;
    endcase
    return v[15:0];
  endfunction

  function automatic bit f_out();
    if (!m_valid) return 1'b0;
    case (m_mode)
      0, 1: return m_e >= m_n;
      2: return !(m_e > 0 && (m_e % m_n) == 0);
      3: return (m_e % m_n) < (m_n + 1) / 2;
      default: return m_e == m_n;
    endcase
  endfunction

  function automatic string auto_tag();
    if (!m_valid) return "R1";
    case (m_mode)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag);
    logic [15:0] ec;
    bit eo;
    ec = f_count();
    eo = f_out();
    checks++;
    if (count !== ec || out !== eo) begin
      fails++;
      $display("FAIL %s: count=%0d out=%0b expected count=%0d out=%0b", tag, count, out, ec, eo);
    end
  endtask

  task automatic cyc(bit ld, int val, int md, bit g, bit tk, string tag = "");
    bit rise;
    load = ld; load_val = val[15:0]; mode = md[2:0]; gate = g; tick = tk;
    @(posedge clk);
    rise = g && !m_gprev;
    m_gprev = g;
    if (ld) begin
      m_mode = (md >= 6) ? md - 4 : md;
      m_n = (val[15:0] == 0) ? 65536 : longint'(val[15:0]);
      m_e = 0;
      m_valid = 1;
    end else if (m_valid && rise && m_mode inside {1, 2, 3, 5}) begin
      m_e = 0;
    end else if (m_valid && tk && (g || m_mode == 1 || m_mode == 5)) begin
      m_e++;
    end
    @(negedge clk);
    chk(tag == "" ? auto_tag() : tag);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned r;
    bit g;
    r = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    chk("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 1, "R1");

    cyc(1, 5, 0, 1, 0, "R2");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, 1, "R4");
    cyc(1, 3, 0, 1, 1, "R11");
    for (int i = 0; i < 2; i++) cyc(0, 0, 0, 1, 1, "R4");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, "R10");
    cyc(0, 0, 0, 1, 1, "R4");

    cyc(1, 4, 1, 0, 0, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 1, "R10");
    cyc(0, 0, 1, 1, 1, "R9");
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 1, 1, "R5");

    cyc(1, 3, 6, 1, 0, "R2");
    for (int i = 0; i < 8; i++) cyc(0, 0, 2, 1, 1, "R6");
    cyc(0, 0, 2, 0, 1, "R10");
    cyc(0, 0, 2, 1, 1, "R9");
    cyc(0, 0, 2, 1, 1, "R11");

    cyc(1, 5, 3, 1, 0, "R2");
    for (int i = 0; i < 11; i++) cyc(0, 0, 3, 1, 1, "R7");
    cyc(1, 4, 7, 1, 0, "R2");
    for (int i = 0; i < 9; i++) cyc(0, 0, 3, 1, 1, "R7");

    cyc(1, 3, 4, 1, 0, "R2");
    for (int i = 0; i < 6; i++) cyc(0, 0, 4, 1, 1, "R8");
    cyc(1, 2, 5, 0, 0, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 0, 5, 0, 1, "R8");
    cyc(0, 0, 5, 1, 0, "R9");
    for (int i = 0; i < 3; i++) cyc(0, 0, 5, 1, 1, "R8");

    cyc(1, 0, 2, 1, 0, "R3");
    for (int i = 0; i < 5; i++) cyc(0, 0, 2, 1, 1, "R3");
    cyc(1, 0, 0, 1, 0, "R3");
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1, 1, "R3");

    g = 1;
    for (int i = 0; i < 4000; i++) begin
      bit ld;
      int val;
      ld = ($urandom % 50) == 0;
      r = $urandom % 8;
      val = (r == 0) ? 0 : (r == 1) ? int'($urandom % 65536) : int'(1 + $urandom % 12);
      if (($urandom % 12) == 0) g = !g;
      cyc(ld, val, int'($urandom % 8), g, ($urandom % 3) != 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule